// File: doc/BRIEF.md
# Defect-Map Shunt Direction Selector

This block decides where a work item goes when the pipeline stage it needs is broken. The pipeline is a grid of chains (columns) and stages (rows). After reset, a sequencer tests every node in a fixed order, one node per cycle. It stores a failed bit for each node in several identical copies of a defect map. Once the sequencer finishes, it raises a done flag and the map answers lookups.

A lookup names a stage and a chain. The block reads the map by taking a bitwise majority vote over the copies. If the named node is broken, it picks the lateral neighbour at the same stage that should take the item:

- A broken neighbour is never picked.
- Between two healthy neighbours, the one with the shorter queue wins.
- If the queues are equal, the shorter lateral link wins.
- If everything is equal, the block picks left.

An edge chain whose only neighbour is broken, or a node with both neighbours broken, gets a no-route answer. Any disagreement between the stored copies drives a mismatch flag. A single upset port lets one stored bit be flipped, so the effect of a corrupted copy can be observed.

Top module: `shunt_select_top`

## Requirements
- R1: While reset is held, `done_o`, `rsp_valid_o` and `map_mismatch_o` are 0 and `test_node_o` is 0.
- R2: After reset, `test_node_o` advances by one each cycle from 0 to 15. Node index = stage*4 + chain. The level on `test_fail_i` (1 = broken) in each cycle is recorded for that node.
- R3: `done_o` rises on the 16th clock edge after reset release and then stays high.
- R4: A lookup made before `done_o` is high answers with `not_ready_o`=1, `dir_o`=00 and `no_route_o`=0.
- R5: Each lookup is answered with `rsp_valid_o`=1 on the next clock edge. A lookup of a healthy node answers `dir_o`=00 (none) and `no_route_o`=0.
- R6: A broken neighbour is never selected. If exactly one neighbour is healthy, that neighbour is selected. Direction codes: 01 = left (chain-1), 10 = right (chain+1).
- R7: When both neighbours are healthy, the one with the smaller queue depth is selected. Depth is 4 bits per node, node n at bits [4n+3:4n] of `q_depth_i`.
- R8: When both queue depths are equal, the neighbour over the shorter lateral link is selected. Default link lengths are: chains 0–1 = 2, chains 1–2 = 1, chains 2–3 = 1.
- R9: When depths and link lengths are both equal, left (01) is selected.
- R10: If no healthy neighbour exists (edge chain with a broken sole neighbour, or both neighbours broken), `no_route_o`=1 and `dir_o`=00.
- R11: Three copies are stored and each map bit is their majority vote. A single flipped copy (upset port: copy index and node index) does not change any answer.
- R12: `map_mismatch_o` is 1 in the cycle after the copies come to differ in any bit, and 0 once they agree again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| test_fail_i | input | 1 | Test result for the node on `test_node_o` (1 = broken) |
| test_node_o | output | 4 | Node currently under test |
| upset_en_i | input | 1 | Flip one stored map bit |
| upset_copy_i | input | 2 | Copy index for the flip |
| upset_node_i | input | 4 | Node index for the flip |
| q_depth_i | input | 64 | Queue depth per node, 4 bits each |
| query_valid_i | input | 1 | Lookup request |
| query_stage_i | input | 2 | Stage of the broken node |
| query_chain_i | input | 2 | Chain of the broken node |
| rsp_valid_o | output | 1 | Lookup answer valid |
| dir_o | output | 2 | 00 none, 01 left, 10 right |
| no_route_o | output | 1 | No healthy neighbour |
| not_ready_o | output | 1 | Lookup made before self-test finished |
| map_mismatch_o | output | 1 | Copies of the map disagree |
| done_o | output | 1 | Self-test complete |

## Verification
The hardest situation to reach is a corrupted copy of the map. In normal operation every copy is written with the same value, so the vote never has anything to resolve.

The bench uses the upset port to flip one copy of a broken node and a different copy of its healthy neighbour. It then repeats the same lookup and confirms the answer is unchanged while the mismatch flag is raised. Finally it flips both bits back and checks that the flag clears.

Not-ready answers are reached by issuing lookups during the 16-cycle self-test window.

// File: rtl/shunt_pkg.sv
package shunt_pkg;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'b00,
    DIR_LEFT  = 2'b01,
    DIR_RIGHT = 2'b10
  } dir_e;

  // Ranking of two candidate neighbours: health, then load, then distance, then left.
  function automatic dir_e rank_sides(input logic l_ok, input logic r_ok,
                                      input int unsigned dl, input int unsigned dr,
                                      input int unsigned ll, input int unsigned lr);
    if (l_ok && r_ok) begin
      if (dl < dr)      return DIR_LEFT;
      else if (dr < dl) return DIR_RIGHT;
      else if (lr < ll) return DIR_RIGHT;
      else              return DIR_LEFT;
    end
    if (l_ok) return DIR_LEFT;
    if (r_ok) return DIR_RIGHT;
    return DIR_NONE;
  endfunction

endpackage

// File: rtl/defect_selftest.sv
module defect_selftest #(
  parameter int unsigned N_NODES = 16,
  parameter int unsigned NW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [NW-1:0] test_node_o,
  output logic          wr_en_o,
  output logic          done_o
);
  localparam logic [NW-1:0] LAST = NW'(N_NODES - 1);

  logic [NW-1:0] idx_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (idx_q == LAST) done_q <= 1'b1;
      else               idx_q  <= idx_q + NW'(1);
    end
  end

  assign test_node_o = idx_q;
  assign wr_en_o     = !done_q;
  assign done_o      = done_q;

  p_step_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && test_node_o != LAST) |=> (test_node_o == $past(test_node_o) + NW'(1)));
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(test_node_o) == LAST));
endmodule

// File: rtl/defect_map_vote.sv
module defect_map_vote #(
  parameter int unsigned N_NODES  = 16,
  parameter int unsigned NW       = 4,
  parameter int unsigned N_COPIES = 3,
  parameter int unsigned KW       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NW-1:0]      wr_node_i,
  input  logic               wr_fail_i,
  input  logic               upset_en_i,
  input  logic [KW-1:0]      upset_copy_i,
  input  logic [NW-1:0]      upset_node_i,
  output logic [N_NODES-1:0] voted_o,
  output logic               disagree_o
);
  localparam int unsigned MAJ = N_COPIES / 2;

  logic [N_NODES-1:0] copy_q [N_COPIES];
  logic [N_NODES-1:0] copy_d [N_COPIES];

  always_comb begin
    for (int k = 0; k < N_COPIES; k++) begin
      copy_d[k] = copy_q[k];
      if (wr_en_i) copy_d[k][wr_node_i] = wr_fail_i;
      if (upset_en_i && (int'(upset_copy_i) == k))
        copy_d[k][upset_node_i] = ~copy_d[k][upset_node_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_COPIES; k++) copy_q[k] <= '0;
    end else begin
      for (int k = 0; k < N_COPIES; k++) copy_q[k] <= copy_d[k];
    end
  end

  always_comb begin
    for (int n = 0; n < N_NODES; n++) begin
      int unsigned cnt;
      cnt = 0;
      for (int k = 0; k < N_COPIES; k++) cnt += 32'(copy_q[k][n]);
      voted_o[n] = (cnt > MAJ);
    end
  end

  always_comb begin
    disagree_o = 1'b0;
    for (int k = 1; k < N_COPIES; k++)
      disagree_o = disagree_o | (|(copy_q[k] ^ copy_q[0]));
  end

  p_vote_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !upset_en_i) |=> $stable(voted_o));
  p_no_upset_no_split_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!disagree_o && !upset_en_i) |=> !disagree_o);
endmodule

// File: rtl/shunt_pick.sv
module shunt_pick
  import shunt_pkg::*;
#(
  parameter int unsigned N_CHAINS = 4,
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned QW       = 4,
  parameter int unsigned LINK_LEN [N_CHAINS-1] = '{2, 1, 1},
  localparam int unsigned N_NODES = N_CHAINS * N_STAGES,
  localparam int unsigned NW      = $clog2(N_NODES),
  localparam int unsigned CW      = $clog2(N_CHAINS),
  localparam int unsigned SW      = $clog2(N_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ready_i,
  input  logic [N_NODES-1:0]    voted_i,
  input  logic [N_NODES*QW-1:0] q_depth_i,
  input  logic                  query_valid_i,
  input  logic [SW-1:0]         query_stage_i,
  input  logic [CW-1:0]         query_chain_i,
  output logic                  rsp_valid_o,
  output dir_e                  dir_o,
  output logic                  no_route_o,
  output logic                  not_ready_o
);
  function automatic int unsigned gap_len(input int unsigned g);
    for (int unsigned j = 0; j < N_CHAINS - 1; j++)
      if (j == g) return LINK_LEN[j];
    return 0;
  endfunction

  logic [NW-1:0] node_w, l_node, r_node;
  logic          has_l, has_r, l_ok, r_ok, self_bad;
  int unsigned   dl, dr, ll, lr;
  dir_e          pick_w;

  assign node_w   = NW'(32'(query_stage_i) * N_CHAINS + 32'(query_chain_i));
  assign l_node   = node_w - NW'(1);
  assign r_node   = node_w + NW'(1);
  assign has_l    = (query_chain_i != '0);
  assign has_r    = (query_chain_i != CW'(N_CHAINS - 1));
  assign l_ok     = has_l && !voted_i[l_node];
  assign r_ok     = has_r && !voted_i[r_node];
  assign self_bad = voted_i[node_w];
  assign dl       = 32'(q_depth_i[int'(l_node)*QW +: QW]);
  assign dr       = 32'(q_depth_i[int'(r_node)*QW +: QW]);
  assign ll       = has_l ? gap_len(32'(query_chain_i) - 1) : 0;
  assign lr       = has_r ? gap_len(32'(query_chain_i)) : 0;
  assign pick_w   = rank_sides(l_ok, r_ok, dl, dr, ll, lr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      dir_o       <= DIR_NONE;
      no_route_o  <= 1'b0;
      not_ready_o <= 1'b0;
    end else begin
      rsp_valid_o <= query_valid_i;
      not_ready_o <= query_valid_i && !ready_i;
      if (!query_valid_i || !ready_i || !self_bad) begin
        dir_o      <= DIR_NONE;
        no_route_o <= 1'b0;
      end else begin
        dir_o      <= pick_w;
        no_route_o <= (pick_w == DIR_NONE);
      end
    end
  end

  p_rsp_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    query_valid_i |=> rsp_valid_o);
  p_left_healthy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && dir_o == DIR_LEFT) |-> ($past(has_l) && !$past(voted_i[l_node])));
  p_right_healthy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && dir_o == DIR_RIGHT) |-> ($past(has_r) && !$past(voted_i[r_node])));
  p_notready_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && not_ready_o) |-> (dir_o == DIR_NONE && !no_route_o && !$past(ready_i)));
  p_noroute_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    no_route_o |-> (dir_o == DIR_NONE && rsp_valid_o));
endmodule

// File: rtl/shunt_select_top.sv
module shunt_select_top
  import shunt_pkg::*;
#(
  parameter int unsigned N_CHAINS = 4,
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned N_COPIES = 3,
  parameter int unsigned QW       = 4,
  parameter int unsigned LINK_LEN [N_CHAINS-1] = '{2, 1, 1},
  localparam int unsigned N_NODES = N_CHAINS * N_STAGES,
  localparam int unsigned NW      = $clog2(N_NODES),
  localparam int unsigned CW      = $clog2(N_CHAINS),
  localparam int unsigned SW      = $clog2(N_STAGES),
  localparam int unsigned KW      = $clog2(N_COPIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_fail_i,
  output logic [NW-1:0]         test_node_o,
  input  logic                  upset_en_i,
  input  logic [KW-1:0]         upset_copy_i,
  input  logic [NW-1:0]         upset_node_i,
  input  logic [N_NODES*QW-1:0] q_depth_i,
  input  logic                  query_valid_i,
  input  logic [SW-1:0]         query_stage_i,
  input  logic [CW-1:0]         query_chain_i,
  output logic                  rsp_valid_o,
  output logic [1:0]            dir_o,
  output logic                  no_route_o,
  output logic                  not_ready_o,
  output logic                  map_mismatch_o,
  output logic                  done_o
);
  logic               wr_en;
  logic [N_NODES-1:0] voted;
  dir_e               dir_w;

  defect_selftest #(.N_NODES(N_NODES), .NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .test_node_o(test_node_o),
    .wr_en_o(wr_en), .done_o(done_o)
  );

  defect_map_vote #(.N_NODES(N_NODES), .NW(NW), .N_COPIES(N_COPIES), .KW(KW)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_node_i(test_node_o),
    .wr_fail_i(test_fail_i), .upset_en_i(upset_en_i), .upset_copy_i(upset_copy_i),
    .upset_node_i(upset_node_i), .voted_o(voted), .disagree_o(map_mismatch_o)
  );

  shunt_pick #(.N_CHAINS(N_CHAINS), .N_STAGES(N_STAGES), .QW(QW), .LINK_LEN(LINK_LEN)) u_pick (
    .clk(clk), .rst_n(rst_n), .ready_i(done_o), .voted_i(voted), .q_depth_i(q_depth_i),
    .query_valid_i(query_valid_i), .query_stage_i(query_stage_i),
    .query_chain_i(query_chain_i), .rsp_valid_o(rsp_valid_o), .dir_o(dir_w),
    .no_route_o(no_route_o), .not_ready_o(not_ready_o)
  );

  assign dir_o = dir_w;
endmodule

// File: tb/shunt_select_top_tb_top.sv
module shunt_select_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_fail;
  logic [3:0]  test_node;
  logic        upset_en = 1'b0;
  logic [1:0]  upset_copy = '0;
  logic [3:0]  upset_node = '0;
  logic [15:0][3:0] depth_tb = '0;
  logic        qv = 1'b0;
  logic [1:0]  qs = '0, qc = '0;
  logic        rsp_valid, no_route, not_ready, mismatch, done;
  logic [1:0]  dir;

  // broken nodes: 1, 4, 5, 10, 13, 14, 15
  logic [15:0] fail_tb = 16'b1110_0100_0011_0010;
  int unsigned gap_tb [3] = '{2, 1, 1};

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;
  assign test_fail = fail_tb[test_node];

  shunt_select_top dut_i (
    .clk(clk), .rst_n(rst_n), .test_fail_i(test_fail), .test_node_o(test_node),
    .upset_en_i(upset_en), .upset_copy_i(upset_copy), .upset_node_i(upset_node),
    .q_depth_i(depth_tb), .query_valid_i(qv), .query_stage_i(qs), .query_chain_i(qc),
    .rsp_valid_o(rsp_valid), .dir_o(dir), .no_route_o(no_route),
    .not_ready_o(not_ready), .map_mismatch_o(mismatch), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {dir, no_route, not_ready}
  function automatic logic [3:0] model(input int s, input int c, input bit rdy);
    int n;
    bit lh, rh;
    logic [1:0] d;
    if (!rdy) return 4'b0001;
    n = s * 4 + c;
    if (!fail_tb[n]) return 4'b0000;
    lh = (c > 0) && !fail_tb[n-1];
    rh = (c < 3) && !fail_tb[n+1];
    if (lh && rh) begin
      if (depth_tb[n-1] != depth_tb[n+1]) d = (depth_tb[n-1] < depth_tb[n+1]) ? 2'b01 : 2'b10;
      else d = (gap_tb[c] < gap_tb[c-1]) ? 2'b10 : 2'b01;
      return {d, 2'b00};
    end
    if (lh) return 4'b0100;
    if (rh) return 4'b1000;
    return 4'b0010;
  endfunction

  task automatic drive_query(input int s, input int c, input bit rdy, input string req);
    qs = 2'(s);
    qc = 2'(c);
    qv = 1'b1;
    exp_q.push_back(model(s, c, rdy));
    tag_q.push_back(req);
  endtask

  task automatic lookup(input int s, input int c, input string req);
    @(negedge clk);
    drive_query(s, c, 1'b1, req);
    @(negedge clk);
    qv = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {28'd0, dir, no_route, not_ready}, {28'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 test_node", test_node, 0);
    check("R1 mismatch", mismatch, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      check("R2 test order", test_node, i);
      check("R3 done early", done, 0);
      if (i == 3) drive_query(0, 1, 1'b0, "R4 not ready");
      if (i == 4) drive_query(1, 1, 1'b0, "R4 not ready");
      if (i == 5) qv = 1'b0;
      @(negedge clk);
    end
    check("R3 done rises", done, 1);
    lookup(0, 1, "R8 shorter link right");
    lookup(2, 1, "R5 healthy node none");
    lookup(3, 0, "R5 healthy edge none");
    lookup(2, 2, "R9 tie goes left");
    lookup(1, 0, "R10 edge sole neighbour broken");
    lookup(3, 2, "R10 both neighbours broken");
    lookup(3, 3, "R10 right edge");
    depth_tb[6] = 4'd15;
    lookup(1, 1, "R6 only right healthy");
    depth_tb[0] = 4'd1;
    depth_tb[2] = 4'd5;
    lookup(0, 1, "R7 shorter queue left");
    depth_tb[0] = 4'd9;
    lookup(0, 1, "R7 shorter queue right");
    depth_tb[9] = 4'd3;
    depth_tb[11] = 4'd2;
    lookup(2, 2, "R7 load beats left tie");
    // corrupt one copy of a broken node and another copy of a healthy neighbour
    @(negedge clk);
    upset_en = 1'b1; upset_copy = 2'd1; upset_node = 4'd1;
    @(negedge clk);
    upset_copy = 2'd2; upset_node = 4'd2;
    @(negedge clk);
    upset_en = 1'b0;
    check("R12 mismatch raised", mismatch, 1);
    depth_tb[0] = 4'd0; depth_tb[2] = 4'd0;
    lookup(0, 1, "R11 vote hides upset");
    lookup(0, 2, "R11 healthy despite upset");
    lookup(0, 0, "R11 healthy neighbour none");
    @(negedge clk);
    upset_en = 1'b1; upset_copy = 2'd1; upset_node = 4'd1;
    @(negedge clk);
    upset_copy = 2'd2; upset_node = 4'd2;
    @(negedge clk);
    upset_en = 1'b0;
    check("R12 mismatch cleared", mismatch, 0);
    lookup(0, 1, "R8 restored map");
    repeat (3) @(negedge clk);
    check("R5 all responses seen", exp_q.size(), 0);
    check("R3 done stays", done, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule